// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between an on-chip requester running on a single clock and an external asynchronous static RAM of 128K bytes. The requester presents one byte access at a time through a valid/ready handshake: a write/read select, a 17-bit word address and, for writes, an 8-bit value. Reads come back as an 8-bit value marked by a one-cycle valid strobe.

On the memory side the controller drives the address bus, an active-low and an active-high chip select, an active-low write strobe and an active-low output enable. It also drives the data pad through a separate output value and output-enable pair, with the pad input returned on its own port. The access windows are counted in clock cycles. The cycle counts come from parameters that give the clock period and the memory's access and write-pulse times in picoseconds, rounded up to whole cycles.

The order of the pin changes is the core of the block. During a read the memory drives the bus. During a write the controller drives it. The output enable is always turned off at least one cycle before the controller turns on its pad drivers. The write strobe ends while the address and data are still held, and the drivers are released one cycle after that.

Top module: `asram_ctrl`

## Requirements
- R1: While idle, `req_ready` is 1, `mem_ce1_n` is 1, `mem_ce2` is 0, `mem_we_n` is 1, `mem_oe_n` is 1 and `mem_dq_oe` is 0. Reset leaves the block idle.
- R2: A request is taken at a clock edge where both `req_valid` and `req_ready` are 1. From the next cycle until the access completes, `req_ready` is 0, and a `req_valid` pulse in that window has no effect on the memory or on the responses.
- R3: A read holds `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC cycles. RD_CYC = max(1, ceil(max(T_ACC_PS, T_OE_PS) / CLK_PERIOD_PS)). The bus is sampled at the end of the last of these cycles, and `rsp_valid` rises exactly RD_CYC clock edges after the accepting edge.
- R4: A write runs in three phases, with both chip selects active throughout. First comes one setup cycle with `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0. Next come WR_CYC = max(1, ceil(T_WP_PS / CLK_PERIOD_PS)) cycles with `mem_we_n`=0 and `mem_dq_oe`=1. Last comes one hold cycle with `mem_we_n`=1 and `mem_dq_oe`=1.
- R5: `mem_dq_oe` is 1 only while `mem_oe_n` is 1, and `mem_oe_n` was already 1 in the cycle before `mem_dq_oe` rises. `mem_we_n` and `mem_oe_n` are never both 0.
- R6: `mem_addr` and `mem_dq_o` stay unchanged from the setup cycle of a write through its hold cycle, including the edge where `mem_we_n` rises.
- R7: A read returns the byte most recently written to the same 17-bit address, across the whole address range, including addresses with bit 16 or bit 0 set.
- R8: `req_ready` returns to 1 exactly WR_CYC+2 edges after the edge that accepts a write.
- R9: `rsp_valid` is high for one cycle per read. `rsp_data` keeps the last read value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write value |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_data | output | 8 | Last read value |
| mem_addr | output | 17 | Memory address bus |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Value driven onto the data pad |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_i | input | 8 | Value seen on the data pad |

## Verification
The bench uses access and write-pulse times that stretch reads to three cycles and write pulses to two, so the wait counter is exercised rather than collapsing to one cycle. A memory model flags any cycle where it and the controller both drive the pad. A controller that enabled its drivers together with the write strobe, or before output enable went high, would trip that flag. The model also commits data only on the rising write strobe, so a controller that released data or address at that edge would store wrong bytes, and the scoreboard read-back would catch them. The bench also checks that a request pulsed mid-read leaves memory untouched and produces no second response, and it checks the exact read latency and write turnaround.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  // One-hot so every pin is decoded from a single flop.
  typedef enum logic [4:0] {
    ST_IDLE   = 5'b00001,
    ST_READ   = 5'b00010,
    ST_WSETUP = 5'b00100,
    ST_WPULSE = 5'b01000,
    ST_WHOLD  = 5'b10000
  } ctl_state_e;

  // Whole clock cycles needed to cover t_ps, never less than one.
  function automatic int unsigned cycles_for(input int unsigned t_ps,
                                             input int unsigned clk_ps);
    int unsigned n;
    if (clk_ps == 0) return 1;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Counter width able to hold values 0 .. n-1.
  function automatic int unsigned count_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/asram_wait_timer.sv
`timescale 1ns/1ps
module asram_wait_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expired = (remain_q == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned RD_CYC = 1,
  parameter int unsigned WR_CYC = 1,
  parameter int unsigned CW     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          capture,
  output logic          idle,
  output logic          sel_act,
  output logic          oe_act,
  output logic          we_act,
  output logic          drv_act
);

  ctl_state_e state_q, state_d;

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            state_d = ST_WSETUP;
          end else begin
            state_d  = ST_READ;
            tmr_load = 1'b1;
            tmr_val  = CW'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (tmr_expired) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = CW'(WR_CYC - 1);
      end
      ST_WPULSE: begin
        if (tmr_expired) state_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign idle    = (state_q == ST_IDLE);
  assign sel_act = (state_q != ST_IDLE);
  assign oe_act  = (state_q == ST_READ);
  assign we_act  = (state_q == ST_WPULSE);
  assign drv_act = (state_q == ST_WPULSE) || (state_q == ST_WHOLD);

  // R2: a taken request makes the controller busy in the next cycle
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !idle);

  // R4: the strobe phase is always entered from the setup phase
  p_pulse_after_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_act) |-> $past(sel_act) && !$past(we_act) && !$past(drv_act));

endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
module asram_datapath #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [DW-1:0] pad_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          rvalid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= pad_in;
    end
  end

  // R9: a response strobe lasts one cycle
  p_rvalid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q |=> !rvalid_q);

  // R9: read data is held between responses
  p_rdata_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_q && $past(rst_n) |-> $stable(rdata_q));

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned AW            = 17,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned T_ACC_PS      = 12000,
  parameter int unsigned T_OE_PS       = 6000,
  parameter int unsigned T_WP_PS       = 12000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int unsigned RD_CYC = cycles_for(max_u(T_ACC_PS, T_OE_PS), CLK_PERIOD_PS);
  localparam int unsigned WR_CYC = cycles_for(T_WP_PS, CLK_PERIOD_PS);
  localparam int unsigned CW     = count_bits(max_u(RD_CYC, WR_CYC));

  logic          accept, capture, idle;
  logic          sel_act, oe_act, we_act, drv_act;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  asram_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .tmr_expired(tmr_expired),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .accept     (accept),
    .capture    (capture),
    .idle       (idle),
    .sel_act    (sel_act),
    .oe_act     (oe_act),
    .we_act     (we_act),
    .drv_act    (drv_act)
  );

  asram_wait_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  asram_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .capture (capture),
    .in_addr (req_addr),
    .in_wdata(req_wdata),
    .pad_in  (mem_dq_i),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .rdata_q (rsp_data),
    .rvalid_q(rsp_valid)
  );

  assign req_ready = idle;
  assign mem_addr  = addr_q;
  assign mem_ce1_n = ~sel_act;
  assign mem_ce2   = sel_act;
  assign mem_oe_n  = ~oe_act;
  assign mem_we_n  = ~we_act;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = drv_act;

  // R1: idle means deselected, strobes high, pad released
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe);

  // R3: output enable only with both selects active and no write strobe
  p_read_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce1_n && mem_ce2 && mem_we_n);

  // R4: the write strobe is only low with the selects active and data driven
  p_strobe_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce1_n && mem_ce2 && mem_dq_oe);

  // R5: pad drivers only while the memory outputs are off
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R5: output enable high for a full cycle before drivers turn on
  p_oe_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  // R6: address and data held across the rising write strobe
  p_we_rise_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o));

endmodule

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;

  localparam int CLK_PS = 20000;
  localparam int TACC   = 50000;
  localparam int TWP    = 30000;
  localparam int RD_CYC = (TACC + CLK_PS - 1) / CLK_PS;   // 3
  localparam int WR_CYC = (TWP + CLK_PS - 1) / CLK_PS;    // 2
  localparam int WDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_data;
  logic [16:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_o, mem_dq_i;

  always #10ns clk = ~clk;

  asram_ctrl #(.CLK_PERIOD_PS(CLK_PS), .T_ACC_PS(TACC), .T_OE_PS(6000), .T_WP_PS(TWP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int vectors = 0, miscompares = 0, cyc = 0;
  int overlap_cnt = 0, table_bad = 0;
  logic [7:0] last_rd = '0;

  // ---------------- behavioural memory stub ----------------
  logic [7:0] smem [int];
  logic [7:0] shadow [int];
  logic sel, mem_drv;
  assign sel     = !mem_ce1_n && mem_ce2;
  assign mem_drv = sel && !mem_oe_n && mem_we_n;

  function automatic logic [7:0] blank_val(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h3C;
  endfunction

  always @* begin
    if (mem_drv) mem_dq_i = smem.exists(int'(mem_addr)) ? smem[int'(mem_addr)]
                                                        : blank_val(int'(mem_addr));
    else         mem_dq_i = 8'h00;
  end

  always @(posedge mem_we_n) begin
    if (rst_n && sel) begin
      if (!mem_dq_oe) table_bad++;
      smem[int'(mem_addr)] = mem_dq_o;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_drv && mem_dq_oe) overlap_cnt++;
      if (!mem_we_n && !sel) table_bad++;
      if (!mem_oe_n && !sel) table_bad++;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_at(input int a);
    return shadow.exists(a) ? shadow[a] : blank_val(a);
  endfunction

  typedef struct { int addr; logic [7:0] data; int acc; } exp_t;
  exp_t sb [$];

  // ---------------- scoreboard monitor ----------------
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "response with nothing outstanding", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_data == e.data, "R7", "read-back data", rsp_data, e.data);
        chk(cyc - e.acc == RD_CYC, "R3", "read latency", cyc - e.acc, RD_CYC);
        last_rd = e.data;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      miscompares++;
      $display("FAIL R2 watchdog expired: got %0d expected %0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- drivers ----------------
  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    bit ok;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    ok = !mem_ce1_n && mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready;
    chk(ok, "R4", "write setup phase", {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b110);
    for (int i = 0; i < WR_CYC; i++) begin
      @(negedge clk);
      ok = !mem_we_n && mem_dq_oe && mem_oe_n && !mem_ce1_n && mem_ce2;
      chk(ok, "R4", "write strobe phase", {mem_we_n, mem_dq_oe}, 2'b01);
      chk(mem_dq_o == d && mem_addr == 17'(a), "R6", "data/address during strobe",
          mem_dq_o, d);
    end
    @(negedge clk);
    ok = mem_we_n && mem_dq_oe && !req_ready && mem_dq_o == d && mem_addr == 17'(a);
    chk(ok, "R6", "write hold phase", {mem_we_n, mem_dq_oe, mem_dq_o}, {2'b11, d});
    @(negedge clk);
    ok = req_ready && mem_ce1_n && !mem_ce2 && !mem_dq_oe && mem_we_n && mem_oe_n;
    chk(ok, "R8", "ready after WR_CYC+2 edges", req_ready, 1);
    shadow[a] = d;
  endtask

  task automatic do_read(input int a);
    exp_t e;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'(a);
    e.addr = a; e.data = expect_at(a); e.acc = cyc + 1;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_oe_n && mem_we_n && !mem_ce1_n && mem_ce2 && !req_ready, "R3",
        "read enables", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b0101);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  int pat_a [6] = '{0, 'h1FFFF, 'h15555, 'h0AAAA, 'h10000, 'h00001};
  logic [7:0] pat_d [6] = '{8'hA5, 8'h5A, 8'hFF, 8'h00, 8'hC3, 8'h3C};

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe
        && !rsp_valid, "R1", "reset pin state", {mem_ce1_n, mem_ce2}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && mem_ce1_n && !mem_ce2 && !mem_dq_oe, "R1", "idle after reset",
        req_ready, 1);

    for (int i = 0; i < 6; i++) do_write(pat_a[i], pat_d[i]);
    for (int i = 5; i >= 0; i--) do_read(pat_a[i]);
    do_read('h12345);                  // never written: stub default
    drain();

    // R9: data held after the strobe, through idle and a later write
    repeat (3) @(negedge clk);
    chk(rsp_data == last_rd, "R9", "read data held while idle", rsp_data, last_rd);
    do_write('h00ABC, 8'h77);
    chk(rsp_data == last_rd, "R9", "read data held across write", rsp_data, last_rd);

    // R7: overwrite and immediate read-back
    do_write('h15555, 8'h81);
    do_read('h15555);
    do_read('h00ABC);
    drain();

    // R2: request pulsed while a read is busy is ignored
    do_read('h0AAAA);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0AAAB; req_wdata = 8'hEE;
    chk(!req_ready, "R2", "ready low while busy", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    chk(sb.size() == 0 && req_ready, "R2", "no extra access started", sb.size(), 0);
    do_read('h0AAAB);                  // must still hold the blank value
    drain();

    // back-to-back mixed traffic
    for (int i = 0; i < 8; i++) begin
      do_write('h1F000 + i, 8'(i * 37 + 1));
      do_read('h1F000 + i);
    end
    drain();
    repeat (4) @(negedge clk);

    chk(overlap_cnt == 0, "R5", "cycles with both sides driving", overlap_cnt, 0);
    chk(table_bad == 0, "R4", "strobe/select rule violations", table_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule